// File: doc/BRIEF.md
# Predicated register move sequencer

This unit executes one register move over a register file in which each operand can be tagged as a scalar or as a vector. A vector operand that is based at register r keeps element i in register r+i. Two optional predicate masks are applied. The source mask selects which source elements are read. The destination mask selects which destination elements are written.

The same move therefore acts as one of several operations, chosen by the two vector tags and by which masks are enabled:

- fill every element (splat)
- fill some elements (sparse splat)
- write one element (insert)
- pull one element out (extract)
- copy a vector
- pack elements (gather)
- unpack elements (scatter)

The unit reads the register file through an address output and a combinational data input. It writes back through an enable, address and data port. It handles at most one element per cycle.

The host samples the operands with a one-cycle start pulse while the unit is idle. `busy` stays high while elements are processed. `done` pulses for one cycle after the last element. The vector length is captured together with the operands at start.

Top module: `pmov_seq`

## Requirements
- R1: After reset, `busy`, `done` and `wr_en` are all low.
- R2: Scalar source, vector destination, no destination mask: registers dst+0 … dst+VL-1 each receive the value of the source register, one write per cycle in ascending order, taking VL busy cycles.
- R3: Scalar source, vector destination, destination mask enabled: for each i < VL, dst+i is written only when mask bit i (bit 0 = element 0) is 1. A single set bit gives a single-element insert. This takes VL busy cycles.
- R4: Vector source, scalar destination: the lowest element i < VL whose source mask bit is 1 is copied to dst. Element 0 is used when the mask is disabled. The operation ends in the cycle of that write, after i+1 busy cycles. If no bit below VL is set, nothing is written and the operation takes VL busy cycles.
- R5: Vector to vector with both masks disabled: src+i is copied to dst+i for every i < VL, in ascending order, over VL busy cycles.
- R6: Vector to vector with only the source mask enabled (gather): the enabled source elements below VL, in ascending order, are written to dst+0, dst+1, … in that order, over VL busy cycles.
- R7: Vector to vector with only the destination mask enabled (scatter): src+0, src+1, … are written in order into the enabled destination slots below VL, in ascending slot order, over VL busy cycles.
- R8: Vector to vector with both masks enabled: the k-th enabled source element is written to the k-th enabled destination slot, for as many pairs as both masks provide below VL.
- R9: Scalar to scalar: the source register is copied to the destination in a single write, in one busy cycle.
- R10: `done` is high for exactly one cycle, in the cycle after the last busy cycle. With VL = 0, `done` is high in the cycle right after start, with no busy cycle and no write.
- R11: A start pulse while the unit is busy or signalling done is ignored. The running operation completes unchanged.
- R12: `wr_en` is only ever high while `busy` is high, and a vector operand's element index never reaches VL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start | input | 1 | Begin a move; sampled only while idle |
| vlen | input | VLW | Vector length; values above MAXVL act as MAXVL |
| src_reg | input | AW | Source register (base register when a vector) |
| src_is_vec | input | 1 | Source is a vector |
| src_mask_en | input | 1 | Apply the source mask |
| src_mask | input | MAXVL | Source mask, bit i for element i |
| dst_reg | input | AW | Destination register (base register when a vector) |
| dst_is_vec | input | 1 | Destination is a vector |
| dst_mask_en | input | 1 | Apply the destination mask |
| dst_mask | input | MAXVL | Destination mask, bit i for element i |
| busy | output | 1 | Elements being processed |
| done | output | 1 | One-cycle completion pulse |
| rd_addr | output | AW | Register-file read address |
| rd_data | input | XLEN | Register-file read data, combinational from rd_addr |
| wr_en | output | 1 | Register-file write enable |
| wr_addr | output | AW | Register-file write address |
| wr_data | output | XLEN | Register-file write data |

## Verification
The start pulse is taken on a rising edge. The first busy cycle, with its write if that element is enabled, follows that edge directly. Each later element follows one cycle after the previous one. `done` comes one cycle after the last busy cycle, or one cycle after start when VL is 0.

The bench samples at the falling edge that follows each rising edge. It numbers these samples from the start edge and predicts, for every sample, whether `busy` is high and which write, if any, is due. It expects `done` at sample n+1 for n busy cycles, and a low `done` at the sample after that.

When both masks are enabled the duration is not predicted. Only the write sequence and the completion pulse are checked in that case.

// File: rtl/pmov_pkg.sv
package pmov_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pmov_walker.sv
// One operand pointer: base register, vector tag, mask and element index.
module pmov_walker #(
  parameter int AW    = 5,
  parameter int MAXVL = 8,
  parameter int VLW   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    base_in,
  input  logic             vec_in,
  input  logic             msk_en_in,
  input  logic [MAXVL-1:0] msk_in,
  input  logic             run,
  input  logic             fire,
  input  logic [VLW-1:0]   vl,
  output logic [AW-1:0]    addr,
  output logic             rdy,
  output logic             is_vec,
  output logic             last
);
  localparam int SW = AW + VLW;

  logic [AW-1:0]    base_q;
  logic             vec_q, men_q;
  logic [MAXVL-1:0] msk_q, msk_sh;
  logic [VLW-1:0]   idx_q, idx_d, idx_nx;
  logic [SW-1:0]    sum;
  logic             step;

  always_comb begin
    msk_sh = msk_q >> idx_q;
    rdy    = !vec_q || !men_q || msk_sh[0];
    step   = run && vec_q && (fire || !rdy);
    idx_nx = idx_q + VLW'(1);
    last   = step && (idx_nx >= vl);
    sum    = SW'(base_q) + SW'(idx_q);
    addr   = vec_q ? sum[AW-1:0] : base_q;
    is_vec = vec_q;
    idx_d  = idx_q;
    if (load)      idx_d = '0;
    else if (step) idx_d = idx_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      vec_q  <= 1'b0;
      men_q  <= 1'b0;
      msk_q  <= '0;
    end else if (load) begin
      base_q <= base_in;
      vec_q  <= vec_in;
      men_q  <= msk_en_in;
      msk_q  <= msk_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  // R12
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && vec_q) |-> (idx_q < vl));
endmodule

// File: rtl/pmov_ctrl.sv
// Sequencing FSM: accepts start, paces elements, raises done.
module pmov_ctrl
  import pmov_pkg::*;
#(
  parameter int MAXVL = 8,
  parameter int VLW   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vlen,
  input  logic           s_rdy,
  input  logic           d_rdy,
  input  logic           s_last,
  input  logic           d_last,
  input  logic           d_vec,
  output logic           load,
  output logic           run,
  output logic           fire,
  output logic [VLW-1:0] vl_q,
  output logic           busy_o,
  output logic           done_o
);
  seq_state_e     st_q, st_d;
  logic [VLW-1:0] vl_eff;
  logic           finish;

  always_comb begin
    vl_eff = (vlen > VLW'(MAXVL)) ? VLW'(MAXVL) : vlen;
    load   = (st_q == ST_IDLE) && start;
    run    = (st_q == ST_RUN);
    fire   = run && s_rdy && d_rdy;
    finish = s_last || d_last || (fire && !d_vec);
    st_d   = st_q;
    case (st_q)
      ST_IDLE: if (start) st_d = (vl_eff == '0) ? ST_FIN : ST_RUN;
      ST_RUN:  if (finish) st_d = ST_FIN;
      default: st_d = ST_IDLE;
    endcase
    busy_o = run;
    done_o = (st_q == ST_FIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    vl_q <= '0;
    else if (load) vl_q <= vl_eff;
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R10
  vl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st_q == ST_IDLE && vlen == '0) |=> (done_o && !busy_o));
  // R11
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start) |=> $stable(vl_q));
  // R9
  scalar_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !d_vec) |=> !busy_o);
endmodule

// File: rtl/pmov_seq.sv
module pmov_seq #(
  parameter int XLEN  = 32,
  parameter int NREG  = 32,
  parameter int MAXVL = 8,
  localparam int AW   = $clog2(NREG),
  localparam int VLW  = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VLW-1:0]   vlen,
  input  logic [AW-1:0]    src_reg,
  input  logic             src_is_vec,
  input  logic             src_mask_en,
  input  logic [MAXVL-1:0] src_mask,
  input  logic [AW-1:0]    dst_reg,
  input  logic             dst_is_vec,
  input  logic             dst_mask_en,
  input  logic [MAXVL-1:0] dst_mask,
  output logic             busy,
  output logic             done,
  output logic [AW-1:0]    rd_addr,
  input  logic [XLEN-1:0]  rd_data,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [XLEN-1:0]  wr_data
);
  logic           load, run, fire;
  logic [VLW-1:0] vl_q;
  logic           s_rdy, d_rdy, s_last, d_last, s_vec, d_vec;
  logic [AW-1:0]  s_addr, d_addr;

  pmov_ctrl #(.MAXVL(MAXVL), .VLW(VLW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen),
    .s_rdy(s_rdy), .d_rdy(d_rdy), .s_last(s_last), .d_last(d_last),
    .d_vec(d_vec), .load(load), .run(run), .fire(fire), .vl_q(vl_q),
    .busy_o(busy), .done_o(done)
  );

  pmov_walker #(.AW(AW), .MAXVL(MAXVL), .VLW(VLW)) src_w (
    .clk(clk), .rst_n(rst_n), .load(load), .base_in(src_reg),
    .vec_in(src_is_vec), .msk_en_in(src_mask_en), .msk_in(src_mask),
    .run(run), .fire(fire), .vl(vl_q), .addr(s_addr), .rdy(s_rdy),
    .is_vec(s_vec), .last(s_last)
  );

  pmov_walker #(.AW(AW), .MAXVL(MAXVL), .VLW(VLW)) dst_w (
    .clk(clk), .rst_n(rst_n), .load(load), .base_in(dst_reg),
    .vec_in(dst_is_vec), .msk_en_in(dst_mask_en), .msk_in(dst_mask),
    .run(run), .fire(fire), .vl(vl_q), .addr(d_addr), .rdy(d_rdy),
    .is_vec(d_vec), .last(d_last)
  );

  always_comb begin
    rd_addr = s_addr;
    wr_en   = fire;
    wr_addr = d_addr;
    wr_data = rd_data;
  end
endmodule

// File: tb/pmov_seq_tb.sv
`timescale 1ns/1ps
module pmov_seq_tb_top;
  localparam int XLEN = 32, NREG = 32, MAXVL = 8, AW = 5, VLW = 4;

  logic clk, rst_n, start;
  logic [VLW-1:0] vlen;
  logic [AW-1:0] src_reg, dst_reg, rd_addr, wr_addr;
  logic src_is_vec, src_mask_en, dst_is_vec, dst_mask_en;
  logic [MAXVL-1:0] src_mask, dst_mask;
  logic busy, done, wr_en;
  logic [XLEN-1:0] rd_data, wr_data;
  logic [XLEN-1:0] regs [NREG];

  int total = 0, bad = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  pmov_seq #(.XLEN(XLEN), .NREG(NREG), .MAXVL(MAXVL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen),
    .src_reg(src_reg), .src_is_vec(src_is_vec), .src_mask_en(src_mask_en),
    .src_mask(src_mask), .dst_reg(dst_reg), .dst_is_vec(dst_is_vec),
    .dst_mask_en(dst_mask_en), .dst_mask(dst_mask), .busy(busy), .done(done),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  assign rd_data = regs[rd_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= 32'hA000_0000 + i * 32'h111;
    end else if (wr_en) begin
      regs[wr_addr] <= wr_data;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic run_op(input int src, input int dst, input bit sv, input bit dv,
                        input bit spe, input logic [7:0] sp,
                        input bit dpe, input logic [7:0] dp,
                        input int vl, input string rq, input bit poke);
    int ea[$];
    logic [31:0] ed[$];
    int sl[$], dl[$];
    logic [31:0] er [NREG];
    int ecyc, n, first;
    bit seen;
    for (int i = 0; i < NREG; i++) er[i] = regs[i];
    ecyc = -1;
    if (!sv && !dv) begin
      if (vl > 0) begin ea.push_back(dst); ed.push_back(regs[src]); end
      ecyc = (vl > 0) ? 1 : 0;
    end else if (!sv && dv) begin
      for (int i = 0; i < vl; i++)
        if (!dpe || dp[i]) begin ea.push_back(dst + i); ed.push_back(regs[src]); end
      ecyc = vl;
    end else if (sv && !dv) begin
      first = -1;
      for (int i = 0; i < vl; i++)
        if (first < 0 && (!spe || sp[i])) first = i;
      if (first >= 0) begin
        ea.push_back(dst); ed.push_back(regs[src + first]); ecyc = first + 1;
      end else ecyc = vl;
    end else begin
      for (int i = 0; i < vl; i++) begin
        if (!spe || sp[i]) sl.push_back(i);
        if (!dpe || dp[i]) dl.push_back(i);
      end
      for (int k = 0; k < sl.size() && k < dl.size(); k++) begin
        ea.push_back(dst + dl[k]); ed.push_back(regs[src + sl[k]]);
      end
      ecyc = (spe && dpe) ? -1 : vl;
    end
    foreach (ea[k]) er[ea[k]] = ed[k];

    src_reg = AW'(src); dst_reg = AW'(dst); src_is_vec = sv; dst_is_vec = dv;
    src_mask_en = spe; src_mask = sp; dst_mask_en = dpe; dst_mask = dp;
    vlen = VLW'(vl); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0; seen = 1'b0;
    while (!seen && n < 40) begin
      n++;
      if (ecyc >= 0)
        chk(busy == (n <= ecyc), rq, $sformatf("busy at cycle %0d", n), busy, n <= ecyc);
      if (wr_en) begin
        chk(busy, "R12", "write outside busy", busy, 1);
        if (ea.size() == 0) chk(1'b0, rq, "unexpected write addr", wr_addr, 0);
        else begin
          chk(wr_addr == AW'(ea[0]) && wr_data == ed[0], rq, "write addr/data",
              {wr_addr, wr_data}, {AW'(ea[0]), ed[0]});
          void'(ea.pop_front()); void'(ed.pop_front());
        end
      end
      if (done) seen = 1'b1;
      else begin
        if (poke && n == 2) begin start = 1'b1; dst_reg = '0; vlen = VLW'(1); end
        else start = 1'b0;
        @(negedge clk);
      end
    end
    start = 1'b0;
    chk(seen, rq, "done seen", seen, 1);
    if (ecyc >= 0) chk(n == ecyc + 1, "R10", {rq, " done cycle"}, n, ecyc + 1);
    chk(ea.size() == 0, rq, "missing writes", ea.size(), 0);
    @(negedge clk);
    chk(!done && !busy, "R10", {rq, " done one cycle"}, done, 0);
    for (int i = 0; i < NREG; i++)
      chk(regs[i] === er[i], rq, $sformatf("reg %0d after op", i), regs[i], er[i]);
  endtask

  task automatic wrap_up;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    wrap_up();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; vlen = '0; src_reg = '0; dst_reg = '0;
    src_is_vec = 1'b0; dst_is_vec = 1'b0; src_mask_en = 1'b0; dst_mask_en = 1'b0;
    src_mask = '0; dst_mask = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !wr_en, "R1", "idle after reset", {busy, done, wr_en}, 0);
    run_op(2, 3, 0, 0, 0, 8'h00, 0, 8'h00, 4, "R9", 0);
    run_op(2, 16, 0, 1, 0, 8'h00, 0, 8'h00, 8, "R2", 0);
    run_op(5, 16, 0, 1, 0, 8'h00, 1, 8'hA5, 8, "R3", 0);
    run_op(6, 16, 0, 1, 0, 8'h00, 1, 8'h10, 6, "R3", 0);
    run_op(8, 4, 1, 0, 1, 8'h28, 0, 8'h00, 8, "R4", 0);
    run_op(8, 4, 1, 0, 0, 8'h00, 0, 8'h00, 5, "R4", 0);
    run_op(8, 4, 1, 0, 1, 8'h00, 0, 8'h00, 5, "R4", 0);
    run_op(8, 4, 1, 0, 1, 8'h80, 0, 8'h00, 4, "R4", 0);
    run_op(8, 16, 1, 1, 0, 8'h00, 0, 8'h00, 7, "R5", 0);
    run_op(8, 16, 1, 1, 1, 8'hCA, 0, 8'h00, 8, "R6", 0);
    run_op(8, 16, 1, 1, 0, 8'h00, 1, 8'h63, 8, "R7", 0);
    run_op(8, 16, 1, 1, 1, 8'h5A, 1, 8'hC3, 8, "R8", 0);
    run_op(2, 16, 0, 1, 0, 8'h00, 0, 8'h00, 0, "R10", 0);
    run_op(8, 16, 1, 1, 0, 8'h00, 0, 8'h00, 0, "R10", 0);
    run_op(9, 20, 1, 1, 0, 8'h00, 0, 8'h00, 6, "R11", 1);
    wrap_up();
  end
endmodule